// File: doc/BRIEF.md
# ATA PIO Strobe Sequencer

This block runs one programmed-I/O access on a parallel ATA bus at a time. An access can be a device-register access or a data-port access. Each access goes through four phases in a fixed order: address setup, strobe active, data hold and cycle recovery. Every phase length is counted in system clocks. The lengths come from a 32-bit timing word. Four such words are kept, one for each combination of device (0 or 1) and access type (register or data). A request names the device and the access type, and the sequencer takes the matching word when it accepts the request.

A request enters on a valid/ready handshake. A request is accepted on a clock where `req_valid` and `req_ready` are both high. `req_ready` is high only when the sequencer is idle, no read response is waiting and no bus reset is held. A requester may hold `req_valid` high for as long as it needs. A read returns its data on a valid/ready response port. The data is held stable until `rsp_ready` is seen. No new request is accepted while a response waits. A device may slow the active strobe through its IORDY line, when the enable bit for that device is set. Two bus-reset inputs abort any access in progress. These inputs model the hard-reset and soft-reset control bits.

Top module: `pio_cycle_gen`

## Requirements
- R1: Each timing word reads back on `cfg_rdata` with all 32 bits exactly as they were written. Writes take effect on the clock edge where `cfg_we` is high.
- R2: The word index is {device, is_data}, so bit 0 selects data (1) or register (0). An accepted request uses the word at index {req_dev, req_is_data}, as that word stood before that clock edge.
- R3: After acceptance the phases run in the order setup, active, hold, recovery, then idle. A phase whose field holds V lasts V+1 clocks. The field positions are: setup in bits [7:0], active in bits [15:8], hold in bits [23:16] and recovery in bits [31:24]. `rd_strobe` (on a read) or `wr_strobe` (on a write) is high only during the active phase. The two strobes are never high together.
- R4: `bus_sel` is high from the first setup clock to the last hold clock, and is low during recovery and idle. While `bus_sel` is high, `bus_addr` and `bus_dev` show the accepted request's address and device.
- R5: A field of zero gives a phase of exactly one clock. An all-zero word gives a four-clock access.
- R6: While the IORDY enable bit of the active device is set and the registered IORDY sample is low, the active phase does not count down and the strobe stays high. Counting resumes once the sample is high. With the enable bit clear, IORDY has no effect.
- R7: On a read, `bus_din` is captured on the clock edge where the strobe deasserts. `rsp_valid` rises when recovery ends. `rsp_rdata` stays stable while `rsp_valid` is high and `rsp_ready` is low. `rsp_valid` falls on the edge where `rsp_ready` is seen.
- R8: On a write, `bus_dout_en` equals `bus_sel`, and `bus_dout` shows the request's write data while it is enabled. On a read, `bus_dout_en` stays low.
- R9: Holding `bus_hard_rst` or `bus_soft_rst` returns the sequencer to idle on the next edge. It drops the strobes and any pending response, and leaves the timing words unchanged.
- R10: `req_ready` is high exactly when the sequencer is idle, no response waits and neither bus reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which counts all phases |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Timing word write enable |
| cfg_sel | input | 2 | Timing word index {device, is_data}, for both write and readback |
| cfg_wdata | input | 32 | Timing word write data |
| cfg_rdata | output | 32 | Readback of the word at `cfg_sel` |
| iordy_en | input | 2 | IORDY stretch enable, one bit per device |
| bus_hard_rst | input | 1 | Bus hard reset, aborts the access |
| bus_soft_rst | input | 1 | Bus soft reset, aborts the access |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_dev | input | 1 | Target device |
| req_is_data | input | 1 | 1 for a data-port access, 0 for a register access |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 3 | Device register address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Read data taken |
| rsp_rdata | output | 16 | Read data |
| bus_sel | output | 1 | Chip select / address valid window |
| bus_dev | output | 1 | Device of the access on the bus |
| bus_addr | output | 3 | Register address on the bus |
| rd_strobe | output | 1 | Read strobe, active high |
| wr_strobe | output | 1 | Write strobe, active high |
| bus_dout | output | 16 | Data driven toward the device |
| bus_dout_en | output | 1 | Output enable for `bus_dout` |
| bus_din | input | 16 | Data from the device |
| iordy | input | 1 | Device ready line |

## Verification
The assertions check some properties on every cycle. The two strobes never overlap, and setup never skips to a later phase. The count stays frozen while a stall is in force, and an asserted bus reset always lands in idle. A held response keeps its data, `req_ready` never overlaps the chip-select window, and a written word is what the register holds. Other properties can only be shown by the bench's scenarios, where a reference model is compared on every clock. These are the exact V+1 phase lengths for each device and access type, and the zero-length corner. They also cover the sampling point of read data, IORDY stalls with the enable set and with it clear, response back-pressure, and the timing words surviving an abort.

// File: rtl/pio_timing_pkg.sv
package pio_timing_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_ACTIVE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_RECOV  = 3'd4
  } phase_e;

  localparam int NUM_FIELDS = 4;
  localparam int FLD_SETUP  = 0;
  localparam int FLD_ACTIVE = 1;
  localparam int FLD_HOLD   = 2;
  localparam int FLD_RECOV  = 3;
endpackage

// File: rtl/pio_timing_regs.sv
module pio_timing_regs #(
  parameter int NSET   = 4,
  parameter int IDX_W  = 2,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic [WORD_W-1:0] lk_word
);
  logic [WORD_W-1:0] regs_q [NSET];

  for (genvar g = 0; g < NSET; g++) begin : g_set
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs_q[g] <= '0;
      else if (wr_en && (int'(wr_idx) == g))
        regs_q[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    lk_word = '0;
    for (int i = 0; i < NSET; i++) begin
      if (int'(rd_idx) == i) rd_data = regs_q[i];
      if (int'(lk_idx) == i) lk_word = regs_q[i];
    end
  end

  assert_wr_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_idx) < NSET) |=> (regs_q[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
  import pio_timing_pkg::*;
#(
  parameter int FIELD_W = 8,
  localparam int WORD_W = NUM_FIELDS * FIELD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  input  logic              stall,
  output phase_e            phase,
  output logic              hold_enter,
  output logic              done
);
  phase_e             phase_q;
  logic [FIELD_W-1:0] cnt_q;
  logic [WORD_W-1:0]  word_q;
  logic               cnt_zero;

  assign cnt_zero   = (cnt_q == '0);
  assign phase      = phase_q;
  assign hold_enter = (phase_q == PH_ACTIVE) && cnt_zero && !stall && !abort;
  assign done       = (phase_q == PH_RECOV) && cnt_zero && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      word_q  <= '0;
    end else if (abort) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start) begin
          phase_q <= PH_SETUP;
          word_q  <= word;
          cnt_q   <= word[FLD_SETUP*FIELD_W +: FIELD_W];
        end
        PH_SETUP: if (cnt_zero) begin
          phase_q <= PH_ACTIVE;
          cnt_q   <= word_q[FLD_ACTIVE*FIELD_W +: FIELD_W];
        end else cnt_q <= cnt_q - 1'b1;
        PH_ACTIVE: if (!stall) begin
          if (cnt_zero) begin
            phase_q <= PH_HOLD;
            cnt_q   <= word_q[FLD_HOLD*FIELD_W +: FIELD_W];
          end else cnt_q <= cnt_q - 1'b1;
        end
        PH_HOLD: if (cnt_zero) begin
          phase_q <= PH_RECOV;
          cnt_q   <= word_q[FLD_RECOV*FIELD_W +: FIELD_W];
        end else cnt_q <= cnt_q - 1'b1;
        PH_RECOV: if (cnt_zero) phase_q <= PH_IDLE;
                  else cnt_q <= cnt_q - 1'b1;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (phase_q == PH_IDLE));
  assert_stall_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !abort && phase_q == PH_ACTIVE) |=> ($stable(cnt_q) && phase_q == PH_ACTIVE));
  assert_setup_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SETUP && !abort) |=> (phase_q == PH_SETUP || phase_q == PH_ACTIVE));
endmodule

// File: rtl/pio_cycle_gen.sv
module pio_cycle_gen
  import pio_timing_pkg::*;
#(
  parameter int NUM_DEV = 2,
  parameter int FIELD_W = 8,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 3,
  localparam int DEV_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  localparam int IDX_W  = DEV_W + 1,
  localparam int WORD_W = NUM_FIELDS * FIELD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_sel,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  input  logic [NUM_DEV-1:0] iordy_en,
  input  logic              bus_hard_rst,
  input  logic              bus_soft_rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic              req_is_data,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_sel,
  output logic [DEV_W-1:0]  bus_dev,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              rd_strobe,
  output logic              wr_strobe,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_dout_en,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              iordy
);
  localparam int NSET = 2 * NUM_DEV;

  logic              abort, start, stall, hold_enter, done;
  phase_e            phase;
  logic [WORD_W-1:0] lk_word;
  logic              iordy_q, write_q, rsp_q;
  logic [DEV_W-1:0]  dev_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  assign abort     = bus_hard_rst || bus_soft_rst;
  assign req_ready = (phase == PH_IDLE) && !rsp_q && !abort;
  assign start     = req_valid && req_ready;
  assign stall     = (phase == PH_ACTIVE) && iordy_en[dev_q] && !iordy_q;

  pio_timing_regs #(.NSET(NSET), .IDX_W(IDX_W), .WORD_W(WORD_W)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_idx(cfg_sel), .wr_data(cfg_wdata),
    .rd_idx(cfg_sel), .rd_data(cfg_rdata),
    .lk_idx({req_dev, req_is_data}), .lk_word(lk_word)
  );

  pio_phase_seq #(.FIELD_W(FIELD_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .abort(abort), .start(start), .word(lk_word),
    .stall(stall), .phase(phase), .hold_enter(hold_enter), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iordy_q <= 1'b1;
      write_q <= 1'b0;
      dev_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      iordy_q <= iordy;
      if (start) begin
        write_q <= req_write;
        dev_q   <= req_dev;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (hold_enter && !write_q) rdata_q <= bus_din;
      if (abort)                   rsp_q <= 1'b0;
      else if (done && !write_q)   rsp_q <= 1'b1;
      else if (rsp_q && rsp_ready) rsp_q <= 1'b0;
    end
  end

  assign bus_sel     = (phase == PH_SETUP) || (phase == PH_ACTIVE) || (phase == PH_HOLD);
  assign bus_dev     = dev_q;
  assign bus_addr    = addr_q;
  assign rd_strobe   = (phase == PH_ACTIVE) && !write_q;
  assign wr_strobe   = (phase == PH_ACTIVE) && write_q;
  assign bus_dout    = wdata_q;
  assign bus_dout_en = bus_sel && write_q;
  assign rsp_valid   = rsp_q;
  assign rsp_rdata   = rdata_q;

  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_strobe && wr_strobe));
  assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_sel);
  assert_rsp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready && !abort) |=> (rsp_valid && $stable(rsp_rdata)));
  assert_dout_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |-> !bus_dout_en);
endmodule

// File: tb/pio_cycle_gen_tb_top.sv
`timescale 1ns/1ps
module pio_cycle_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [1:0]  ien = '0;
  logic        hrst = 1'b0, srst = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic        req_dev = 1'b0, req_is_data = 1'b0, req_write = 1'b0;
  logic [2:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid, rsp_ready = 1'b1;
  logic [15:0] rsp_rdata;
  logic        bus_sel, bus_dev, rd_strobe, wr_strobe, bus_dout_en;
  logic [2:0]  bus_addr;
  logic [15:0] bus_dout;
  logic [15:0] bus_din = 16'h0000;
  logic        iordy = 1'b1;

  always #2 clk = ~clk;

  pio_cycle_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .iordy_en(ien),
    .bus_hard_rst(hrst), .bus_soft_rst(srst),
    .req_valid(req_valid), .req_ready(req_ready), .req_dev(req_dev),
    .req_is_data(req_is_data), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .bus_sel(bus_sel), .bus_dev(bus_dev),
    .bus_addr(bus_addr), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
    .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .bus_din(bus_din),
    .iordy(iordy)
  );

  int ntot = 0, nbad = 0;
  bit done_flag = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    ntot++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // reference model: phase 0 idle, 1 setup, 2 active, 3 hold, 4 recovery
  logic [31:0] mregs [4];
  int          mph, mcnt;
  bit          mrsp, m_acc, miordy, mwr, mdev;
  logic [2:0]  maddr;
  logic [15:0] mwdata, mcap;
  logic [31:0] mword;

  always @(posedge clk) begin
    if (!rst_n) begin
      mph = 0; mcnt = 0; mrsp = 0; m_acc = 0; miordy = 1; mcap = '0;
      mwr = 0; mdev = 0; maddr = '0; mwdata = '0;
      for (int i = 0; i < 4; i++) mregs[i] = '0;
    end else begin
      bit rdy;
      rdy = (mph == 0) && !mrsp && !hrst && !srst;
      m_acc = 0;
      if (hrst || srst) begin
        mph = 0; mrsp = 0;
      end else begin
        if (mrsp && rsp_ready) mrsp = 0;
        case (mph)
          0: if (req_valid && rdy) begin
            mword = mregs[{req_dev, req_is_data}];
            mwr = req_write; mdev = req_dev; maddr = req_addr; mwdata = req_wdata;
            mph = 1; mcnt = int'(mword[7:0]); m_acc = 1;
          end
          1: if (mcnt == 0) begin mph = 2; mcnt = int'(mword[15:8]); end else mcnt--;
          2: if (!(ien[mdev] && !miordy)) begin
            if (mcnt == 0) begin
              mph = 3; mcnt = int'(mword[23:16]);
              if (!mwr) mcap = bus_din;
            end else mcnt--;
          end
          3: if (mcnt == 0) begin mph = 4; mcnt = int'(mword[31:24]); end else mcnt--;
          4: if (mcnt == 0) begin mph = 0; if (!mwr) mrsp = 1; end else mcnt--;
          default: mph = 0;
        endcase
      end
      if (cfg_we) mregs[cfg_sel] = cfg_wdata;
      miordy = iordy;
    end
  end

  bit cmp_on = 1'b0;
  always begin
    @(negedge clk); #1;
    if (cmp_on && !done_flag) begin
      bit esel, erdy;
      esel = (mph >= 1 && mph <= 3);
      erdy = (mph == 0) && !mrsp && !hrst && !srst;
      chk(req_ready == erdy, "R10", "req_ready", 32'(req_ready), 32'(erdy));
      chk(bus_sel == esel, "R4", "bus_sel", 32'(bus_sel), 32'(esel));
      chk(rd_strobe == (mph == 2 && !mwr), "R3", "rd_strobe", 32'(rd_strobe), 32'(mph == 2 && !mwr));
      chk(wr_strobe == (mph == 2 && mwr), "R3", "wr_strobe", 32'(wr_strobe), 32'(mph == 2 && mwr));
      chk(bus_dout_en == (esel && mwr), "R8", "bus_dout_en", 32'(bus_dout_en), 32'(esel && mwr));
      chk(rsp_valid == mrsp, "R7", "rsp_valid", 32'(rsp_valid), 32'(mrsp));
      if (esel) begin
        chk(bus_addr == maddr && bus_dev == mdev, "R4", "addr/dev",
            {28'd0, bus_dev, bus_addr}, {28'd0, mdev, maddr});
        if (mwr) chk(bus_dout == mwdata, "R8", "bus_dout", 32'(bus_dout), 32'(mwdata));
      end
      if (mrsp) chk(rsp_rdata == mcap, "R7", "rsp_rdata", 32'(rsp_rdata), 32'(mcap));
    end
  end

  task automatic wr_reg(input logic [1:0] idx, input logic [31:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = idx; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] idx, input logic [31:0] exp, input string req);
    @(negedge clk); cfg_sel = idx; #1;
    chk(cfg_rdata == exp, req, "cfg_rdata", cfg_rdata, exp);
  endtask

  task automatic start_req(input bit dev, input bit dat, input bit wr,
                           input logic [2:0] a, input logic [15:0] wd, input logic [15:0] din);
    @(negedge clk);
    req_valid = 1'b1; req_dev = dev; req_is_data = dat; req_write = wr;
    req_addr = a; req_wdata = wd; bus_din = din;
    do begin @(posedge clk); #1; end while (!m_acc);
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do begin @(posedge clk); #1; end while (!(mph == 0 && !mrsp));
  endtask

  task automatic wait_phase(input int p);
    do begin @(posedge clk); #1; end while (mph != p);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      nbad++; ntot++;
      $display("FAIL R3 watchdog actual=hung expected=complete");
      $display("  test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready == 1'b0 || req_ready == 1'b1, "R10", "ready known", 32'(req_ready), 32'(1));
    chk(bus_sel == 1'b0 && rsp_valid == 1'b0, "R4", "reset outputs",
        {30'd0, bus_sel, rsp_valid}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk(req_ready == 1'b1, "R10", "ready after reset", 32'(req_ready), 32'(1));
    cmp_on = 1'b1;

    // R1: full-width readback, including small probe patterns
    wr_reg(2'd2, 32'h0000_0002); rd_reg(2'd2, 32'h0000_0002, "R1");
    wr_reg(2'd2, 32'h0000_0005); rd_reg(2'd2, 32'h0000_0005, "R1");
    wr_reg(2'd0, 32'hFFFF_FFFF); rd_reg(2'd0, 32'hFFFF_FFFF, "R1");
    wr_reg(2'd1, 32'hA5C3_0F81); rd_reg(2'd1, 32'hA5C3_0F81, "R1");

    // R2: distinct words per device and access type
    wr_reg(2'd0, 32'h02_01_03_01);
    wr_reg(2'd1, 32'h01_02_00_02);
    wr_reg(2'd2, 32'h03_00_02_00);
    wr_reg(2'd3, 32'h00_03_01_03);
    rd_reg(2'd3, 32'h00_03_01_03, "R1");
    start_req(0, 0, 1, 3'd7, 16'hBEEF, 16'h0); wait_idle();   // R2 R3 R8 write
    start_req(0, 1, 0, 3'd0, 16'h0, 16'h1234); wait_idle();   // R2 R7 read
    start_req(1, 0, 0, 3'd5, 16'h0, 16'hC0DE); wait_idle();   // R2 read
    start_req(1, 1, 1, 3'd2, 16'h5A5A, 16'h0); wait_idle();   // R2 write

    // R5: all-zero word gives single-clock phases
    wr_reg(2'd0, 32'h0);
    start_req(0, 0, 0, 3'd1, 16'h0, 16'h7777); wait_idle();
    start_req(0, 0, 1, 3'd4, 16'h9999, 16'h0); wait_idle();

    // R6: IORDY stall enabled for device 0
    wr_reg(2'd1, 32'h01_01_02_01);
    ien = 2'b01;
    @(negedge clk); iordy = 1'b0;
    start_req(0, 1, 0, 3'd0, 16'h0, 16'hAB12);
    wait_phase(2);
    repeat (6) @(negedge clk);
    iordy = 1'b1;
    wait_idle();
    // R6: device 1 with enable clear, IORDY low has no effect
    @(negedge clk); iordy = 1'b0;
    start_req(1, 0, 1, 3'd3, 16'h4321, 16'h0); wait_idle();
    @(negedge clk); iordy = 1'b1; ien = 2'b00;

    // R7: response back-pressure
    @(negedge clk); rsp_ready = 1'b0;
    start_req(1, 1, 0, 3'd6, 16'h0, 16'h6E6E);
    do begin @(posedge clk); #1; end while (!mrsp);
    repeat (5) @(negedge clk);
    rsp_ready = 1'b1;
    wait_idle();

    // R9: hard reset during active, soft reset during setup
    wr_reg(2'd1, 32'h05_06_08_04);
    start_req(0, 1, 0, 3'd2, 16'h0, 16'h1111);
    wait_phase(2);
    @(negedge clk); hrst = 1'b1;
    @(negedge clk); hrst = 1'b0;
    start_req(0, 1, 1, 3'd2, 16'h2222, 16'h0);
    @(negedge clk); srst = 1'b1;
    repeat (2) @(negedge clk); srst = 1'b0;
    rd_reg(2'd1, 32'h05_06_08_04, "R9");
    rd_reg(2'd3, 32'h00_03_01_03, "R9");
    start_req(0, 1, 0, 3'd3, 16'h0, 16'h3333); wait_idle();

    repeat (4) @(negedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
    end
  end
endmodule